// File: doc/BRIEF.md
# Digital Automatic Gain Control Loop

This block closes a digital automatic gain control loop around an ADC whose full scale can be adjusted. On each cycle where a level estimate is valid, the estimate is compared with a programmed target level. The difference is then integrated into an attenuation accumulator. When the level is above target, attenuation rises at the attack rate. When the level is below target, attenuation falls at a decay rate, which is the attack rate slowed by a factor of sqrt(2) for each step of the decay setting.

Independently of the level path, an overload strobe from the ADC adds a burst of attenuation on every cycle it is high. The size of that burst doubles with each step of a 3-bit overload weight. The accumulator saturates at both ends. Its upper bits form the attenuation word that drives the full-scale control.

After reset the accumulator is zero. The loop only moves while the enable input is high.

Top module: `agc_loop`

## Requirements
- R1: After the asynchronous reset the attenuation word `atten` is zero.
- R2: While `en` is low the accumulator holds its value, whatever the level, valid and overload inputs do.
- R3: With `en` and `lvl_valid` high and `lvl > target`, the accumulator grows by `(lvl - target) << atk_cfg` in that cycle.
- R4: With `en` and `lvl_valid` high, `lvl < target` and `dcy_cfg` even, the accumulator shrinks by `((target - lvl) << atk_cfg) >> (dcy_cfg/2)`.
- R5: With `dcy_cfg` odd, the decay step is the R4 value, shifted by `floor(dcy_cfg/2)`, then scaled to `floor(x*181/256)` (approximately 1/sqrt(2)).
- R6: With `lvl_valid` low, or with `lvl == target`, the level path adds nothing to the accumulator.
- R7: In each enabled cycle with `ovl_evt` high, `OVL_BASE << ovl_cfg` (base 256 by default) is added, on top of any level-path step in the same cycle.
- R8: The sum of the accumulator and all steps is clamped at zero, with no wrap below zero.
- R9: The sum is clamped at `2^ACC_W - 1`, so `atten` saturates at all ones (4095 by default), with no wrap.
- R10: `atten` equals the accumulator shifted right by `ACC_W - ATT_W` bits (8 by default), and it is registered one clock after the inputs that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Loop enable; the loop holds while this is low |
| lvl_valid | input | 1 | Level estimate valid this cycle |
| lvl | input | LVL_W | Measured signal level, unsigned |
| target | input | LVL_W | Target level, unsigned |
| ovl_evt | input | 1 | ADC overload event strobe |
| atk_cfg | input | 4 | Attack rate setting (left shift of the error) |
| dcy_cfg | input | 4 | Decay slow-down setting (half-power-of-two steps) |
| ovl_cfg | input | 3 | Overload weight (left shift of the base step) |
| atten | output | ATT_W | Attenuation control word |

## Verification
Assertions inside the design check, on every cycle, several structural properties:
- the hold when disabled;
- that attack and decay steps never occur together;
- that the level path is silent when no valid level is present;
- that the overload step is a single power of two;
- that the accumulator moves in the direction its inputs demand;
- that it lands on the rails when a step overshoots.

The exact step sizes can only be shown by the bench scenarios. These cover the attack size for a given shift, the even and odd decay scaling, the overload weight, and the combination of overload and level steps. The bench compares each cycle's attenuation word against a model built from the requirements, through saturation at both rails.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef logic [3:0] rate_cfg_t;
  typedef logic [2:0] ovl_cfg_t;
  localparam int unsigned INV_SQRT2_Q8 = 181;
endpackage

// File: rtl/agc_rate.sv
module agc_rate
  import agc_pkg::*;
#(
  parameter int unsigned LVL_W   = 16,
  parameter int unsigned DELTA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic [LVL_W-1:0]   target_i,
  input  rate_cfg_t          atk_i,
  input  rate_cfg_t          dcy_i,
  output logic [DELTA_W-1:0] up_o,
  output logic [DELTA_W-1:0] down_o
);
  localparam int unsigned PROD_W = DELTA_W + 8;

  logic               above, below;
  logic [LVL_W-1:0]   mag;
  logic [DELTA_W-1:0] scaled, halved, dec_step;
  logic [PROD_W-1:0]  prod;

  always_comb begin
    above    = lvl_i > target_i;
    below    = lvl_i < target_i;
    mag      = above ? (lvl_i - target_i) : (target_i - lvl_i);
    scaled   = DELTA_W'(mag) << atk_i;
    halved   = scaled >> dcy_i[3:1];
    prod     = {8'd0, halved} * PROD_W'(INV_SQRT2_Q8);
    dec_step = dcy_i[0] ? prod[PROD_W-1:8] : halved;
    up_o     = (valid_i && above) ? scaled : '0;
    down_o   = (valid_i && below) ? dec_step : '0;
  end

  // R6: no level step without a valid estimate
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (up_o == '0 && down_o == '0));

  // R3: attack and decay never act together
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o != '0) |-> (down_o == '0));
endmodule

// File: rtl/agc_ovl.sv
module agc_ovl
  import agc_pkg::*;
#(
  parameter int unsigned STEP_W   = 20,
  parameter int unsigned OVL_BASE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  ovl_cfg_t          cfg_i,
  output logic [STEP_W-1:0] step_o
);
  always_comb begin
    step_o = evt_i ? (STEP_W'(OVL_BASE) << cfg_i) : '0;
  end

  // R7: each overload burst is a single power-of-two weight
  p_pow2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |-> ($countones(step_o) == 1));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |-> (step_o == '0));
endmodule

// File: rtl/agc_accum.sv
module agc_accum #(
  parameter int unsigned ACC_W   = 20,
  parameter int unsigned DELTA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [DELTA_W-1:0] up_i,
  input  logic [DELTA_W-1:0] down_i,
  input  logic [ACC_W-1:0]   ovl_i,
  output logic [ACC_W-1:0]   acc_o
);
  localparam int unsigned SUM_W = DELTA_W + 2;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;
  localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(ACC_MAX);

  logic [ACC_W-1:0]        acc_q, acc_d, clamped;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed(SUM_W'(acc_q)) + $signed(SUM_W'(up_i))
        + $signed(SUM_W'(ovl_i)) - $signed(SUM_W'(down_i));
    if (sum < 0)            clamped = '0;
    else if (sum > SUM_MAX) clamped = ACC_MAX;
    else                    clamped = ACC_W'(sum);
    acc_d = en_i ? clamped : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R2: accumulator frozen while disabled
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(acc_q));

  // R3: without a decay step the accumulator never falls
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && down_i == '0) |=> (acc_q >= $past(acc_q)));

  // R4: with only a decay step the accumulator never rises
  p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && up_i == '0 && ovl_i == '0) |=> (acc_q <= $past(acc_q)));

  // R8: decay larger than the content lands on zero
  p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && up_i == '0 && ovl_i == '0 && down_i >= DELTA_W'(acc_q)) |=> (acc_q == '0));

  // R9: attack beyond full range lands on the top code
  p_ceil_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && down_i == '0 && up_i >= DELTA_W'(ACC_MAX)) |=> (acc_q == ACC_MAX));
endmodule

// File: rtl/agc_loop.sv
module agc_loop
  import agc_pkg::*;
#(
  parameter int unsigned LVL_W    = 16,
  parameter int unsigned ACC_W    = 20,
  parameter int unsigned ATT_W    = 12,
  parameter int unsigned OVL_BASE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             lvl_valid,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] target,
  input  logic             ovl_evt,
  input  logic [3:0]       atk_cfg,
  input  logic [3:0]       dcy_cfg,
  input  logic [2:0]       ovl_cfg,
  output logic [ATT_W-1:0] atten
);
  localparam int unsigned DELTA_W = LVL_W + 16;
  localparam int unsigned FRAC_W  = ACC_W - ATT_W;

  logic [DELTA_W-1:0] up_step, down_step;
  logic [ACC_W-1:0]   ovl_step, acc;

  agc_rate #(.LVL_W(LVL_W), .DELTA_W(DELTA_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .valid_i(lvl_valid), .lvl_i(lvl),
    .target_i(target), .atk_i(atk_cfg), .dcy_i(dcy_cfg),
    .up_o(up_step), .down_o(down_step)
  );

  agc_ovl #(.STEP_W(ACC_W), .OVL_BASE(OVL_BASE)) u_ovl (
    .clk(clk), .rst_n(rst_n), .evt_i(ovl_evt), .cfg_i(ovl_cfg),
    .step_o(ovl_step)
  );

  agc_accum #(.ACC_W(ACC_W), .DELTA_W(DELTA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en_i(en), .up_i(up_step),
    .down_i(down_step), .ovl_i(ovl_step), .acc_o(acc)
  );

  assign atten = acc[ACC_W-1:FRAC_W];

  // R1: output zero while reset is applied
  p_rst_r1: assert property (@(posedge clk) !rst_n |-> (atten == '0));
endmodule

// File: tb/test_agc_loop.sv
module test_agc_loop;
  localparam int unsigned LVL_W = 16;
  localparam int unsigned ACC_W = 20;
  localparam int unsigned ATT_W = 12;
  localparam longint      ACC_MAX = (64'sd1 << ACC_W) - 1;

  typedef struct {
    logic [ATT_W-1:0] exp;
    string            req;
  } item_t;

  logic             clk, rst_n, en, lvl_valid, ovl_evt;
  logic [LVL_W-1:0] lvl, target;
  logic [3:0]       atk_cfg, dcy_cfg;
  logic [2:0]       ovl_cfg;
  logic [ATT_W-1:0] atten;

  int     checks, errors;
  longint acc_m;
  item_t  q[$];
  bit     done;

  agc_loop i_agc_loop (
    .clk(clk), .rst_n(rst_n), .en(en), .lvl_valid(lvl_valid), .lvl(lvl),
    .target(target), .ovl_evt(ovl_evt), .atk_cfg(atk_cfg),
    .dcy_cfg(dcy_cfg), .ovl_cfg(ovl_cfg), .atten(atten)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic void finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected word
  task automatic cyc(input bit e, input bit v, input int l, input int t,
                     input bit o, input int a, input int d, input int oc,
                     input string req);
    longint mag, step, nxt;
    item_t  it;
    @(negedge clk);
    en = e; lvl_valid = v; lvl = LVL_W'(l); target = LVL_W'(t);
    ovl_evt = o; atk_cfg = 4'(a); dcy_cfg = 4'(d); ovl_cfg = 3'(oc);
    if (e) begin
      nxt = acc_m;
      if (v && l > t) nxt += longint'(l - t) << a;          // R3
      if (v && l < t) begin
        mag  = longint'(t - l) << a;
        step = mag >> (d / 2);                              // R4
        if (d % 2 == 1) step = (step * 181) >> 8;           // R5
        nxt -= step;
      end
      if (o) nxt += longint'(256) << oc;                    // R7
      if (nxt < 0) nxt = 0;                                 // R8
      if (nxt > ACC_MAX) nxt = ACC_MAX;                     // R9
      acc_m = nxt;
    end
    it.exp = ATT_W'(acc_m >> (ACC_W - ATT_W));              // R10
    it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compares after each active edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (atten !== it.exp) begin
          errors++;
          $display("FAIL %s: atten=%0d expected=%0d", it.req, atten, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; acc_m = 0; done = 0;
    rst_n = 1'b0; en = 0; lvl_valid = 0; ovl_evt = 0;
    lvl = '0; target = '0; atk_cfg = '0; dcy_cfg = '0; ovl_cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (atten !== '0) begin
      errors++;
      $display("FAIL R1: atten=%0d expected=0", atten);
    end
    rst_n = 1'b1;

    // R2: disabled loop ignores level and overload
    cyc(0, 1, 5000, 100, 1, 8, 0, 7, "R2");
    cyc(0, 1, 5000, 100, 1, 8, 0, 7, "R2");
    // R3: attack steps
    for (int i = 0; i < 4; i++) cyc(1, 1, 1100, 1000, 0, 4, 0, 0, "R3");
    cyc(1, 1, 1300, 1000, 0, 6, 0, 0, "R3");
    // R6: equal level or invalid estimate leaves it alone
    cyc(1, 1, 1000, 1000, 0, 6, 0, 0, "R6");
    cyc(1, 0, 9000, 1000, 0, 15, 0, 0, "R6");
    cyc(1, 0, 0, 1000, 0, 15, 0, 0, "R6");
    // R4: even decay settings
    cyc(1, 1, 800, 1000, 0, 4, 2, 0, "R4");
    cyc(1, 1, 800, 1000, 0, 4, 0, 0, "R4");
    cyc(1, 1, 900, 1000, 0, 5, 4, 0, "R4");
    // R5: odd decay settings
    cyc(1, 1, 800, 1000, 0, 4, 3, 0, "R5");
    cyc(1, 1, 700, 1000, 0, 5, 1, 0, "R5");
    // R7: overload weights, alone and with level steps
    cyc(1, 0, 0, 0, 1, 0, 0, 7, "R7");
    cyc(1, 0, 0, 0, 1, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, 1, 0, 0, 3, "R7");
    cyc(1, 1, 900, 1000, 1, 4, 1, 5, "R7");
    cyc(1, 1, 1200, 1000, 1, 3, 0, 2, "R7");
    // R2: hold a non-zero value
    cyc(0, 1, 0, 60000, 1, 15, 0, 7, "R2");
    // R9: saturation at the top
    cyc(1, 1, 65535, 0, 0, 15, 0, 0, "R9");
    cyc(1, 1, 65535, 0, 1, 15, 0, 7, "R9");
    cyc(1, 1, 2000, 1000, 1, 4, 0, 7, "R9");
    // R10: single step off the rail is visible one clock later
    cyc(1, 1, 900, 1000, 0, 12, 0, 0, "R10");
    // R8: saturation at zero
    cyc(1, 1, 0, 65535, 0, 15, 0, 0, "R8");
    cyc(1, 1, 0, 65535, 0, 15, 7, 0, "R8");
    cyc(1, 1, 990, 1000, 0, 0, 0, 0, "R8");
    // R3: climb again from zero
    cyc(1, 1, 1500, 1000, 0, 2, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule